// File: doc/BRIEF.md
# Flash Array Controller with Register Interface

This block is an on-chip non-volatile memory controller that software drives through four word registers on a simple write bus. It holds a small flash array model split into a main region for program code and a separate user-data region. Both regions are reached through the same address register. Software loads a start address and can then erase the page that holds that address, or wipe the whole main region at once. It can also stream 32-bit data words into consecutive locations. After each programmed word the address steps forward on its own.

Each operation keeps a busy flag high for a fixed, parameterised number of cycles. The array changes in the cycle the operation finishes. A write-data-ready flag tells software when the next data word may be sent. Writes that arrive while the controller is busy are discarded and raise a sticky error flag. Operations aimed outside both regions are refused and raise an invalid-address flag. The whole register interface is frozen unless an external clock-enable input is high. A separate combinational read port returns array contents for fetch or verification.

Top module: `nvm_flash_ctrl`

## Requirements
- R1: After reset the status word (offset 0xC) reads 0x1 (write-data-ready set; busy, invalid-address and error clear), the address register reads 0, and every array word reads 0xFFFFFFFF.
- R2: A write to offset 0x0 stores bits 31:2 of the data as the address, with bits 1:0 read back as zero at offset 0x0.
- R3: A write to offset 0x4 while idle, at a valid address, programs one word. It sets busy (status bit 1) and clears write-data-ready (status bit 0) for exactly PROG_CYC cycles. The stored word then becomes the old value ANDed with the data, and both flags return to idle.
- R4: Each completed word program adds 4 to the address register.
- R5: Writing command bit 0 (offset 0x8) holds busy for exactly ERASE_CYC cycles. It then sets every word of the page holding the address to all ones and leaves every other page unchanged.
- R6: Writing command bit 1 holds busy for exactly MASS_CYC cycles. It then sets every main-region word to all ones and leaves the user-data region unchanged. When bits 0 and 1 are written together, the mass erase is performed.
- R7: A write to offset 0x0, 0x4 or 0x8 while busy is dropped and sets the error flag (status bit 3). The flag stays set until a command write with bit 3 set is made while idle, which clears both error and invalid-address.
- R8: A data write or page erase at an address outside both regions sets the invalid-address flag (status bit 2). No busy period starts and the array does not change.
- R9: While clk_en is low, writes to all registers are ignored: the address, status and array keep their values.
- R10: The user-data region starts at INFO_BASE. Word programming and page erase there behave as in the main region.
- R11: The read port returns the stored word for addresses in either region and zero for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable from the clock-control register; gates all register writes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset (bits 3:2 select the register) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the offset on bus_addr (combinational) |
| rd_addr | input | 32 | Array read byte address |
| rd_data | output | 32 | Array word at rd_addr, zero outside both regions |

## Verification
A write accepted at a clock edge is visible in status on the following cycle: busy is high and, for a program, write-data-ready is low. Busy then stays high for exactly PROG_CYC, ERASE_CYC or MASS_CYC cycles, and the array and address register change in the edge that drops busy. The bench drives every write for one cycle between falling edges. It then reads status at each falling edge and counts how many falling edges see busy high, comparing that count with the cycle parameter. Array contents and the address are read only after busy has been seen low. Checks on refused, dropped and gated writes are read back in the cycle right after the write and again after any busy period has ended.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PAGE = 2'd1,
    OP_MASS = 2'd2,
    OP_PROG = 2'd3
  } op_e;

  // register select (bus_addr[3:2])
  localparam logic [1:0] REG_ADDR  = 2'd0;
  localparam logic [1:0] REG_WDATA = 2'd1;
  localparam logic [1:0] REG_CMD   = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  // command bits
  localparam int CMD_PAGE = 0;
  localparam int CMD_MASS = 1;
  localparam int CMD_CLR  = 3;

  // status bits
  localparam int ST_WDR  = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_INV  = 2;
  localparam int ST_ERR  = 3;
endpackage

// File: rtl/nvm_addr_map.sv
module nvm_addr_map #(
  parameter logic [31:0] MAIN_BASE  = 32'h0000_0000,
  parameter logic [31:0] INFO_BASE  = 32'h0FE0_0000,
  parameter int          PAGE_WORDS = 4,
  parameter int          MAIN_PAGES = 4,
  parameter int          INFO_PAGES = 1,
  parameter int          IDXW       = 5
) (
  input  logic [31:0]     addr,
  output logic            hit,
  output logic [IDXW-1:0] idx
);
  localparam int MAIN_WORDS = PAGE_WORDS * MAIN_PAGES;
  localparam int INFO_WORDS = PAGE_WORDS * INFO_PAGES;
  localparam int MAIN_BYTES = MAIN_WORDS * 4;
  localparam int INFO_BYTES = INFO_WORDS * 4;

  logic [32:0] moff;
  logic [32:0] ioff;
  logic        in_main;
  logic        in_info;

  always_comb begin
    moff    = {1'b0, addr} - {1'b0, MAIN_BASE};
    ioff    = {1'b0, addr} - {1'b0, INFO_BASE};
    in_main = !moff[32] && (moff < 33'(MAIN_BYTES));
    in_info = !ioff[32] && (ioff < 33'(INFO_BYTES));
    hit     = in_main || in_info;
    if (in_main) begin
      idx = moff[IDXW+1:2];
    end else if (in_info) begin
      idx = IDXW'(MAIN_WORDS) + ioff[IDXW+1:2];
    end else begin
      idx = '0;
    end
  end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 8,
  parameter int MASS_CYC  = 10,
  parameter int IDXW      = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            bus_wr,
  input  logic [1:0]      bus_sel,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [31:0]     cur_addr,
  input  logic            cur_hit,
  input  logic [IDXW-1:0] cur_idx,
  output logic            st_busy,
  output logic            st_wdr,
  output logic            st_inv,
  output logic            st_err,
  output logic            done,
  output op_e             done_op,
  output logic [IDXW-1:0] done_idx,
  output logic [31:0]     done_data
);
  localparam int MAX_AB = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAXC   = (MAX_AB > MASS_CYC) ? MAX_AB : MASS_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  logic [31:0]     addr_q, addr_n;
  logic [31:0]     data_q, data_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  op_e             op_q, op_n;
  logic            busy_q, busy_n;
  logic            wdr_q, wdr_n;
  logic            inv_q, inv_n;
  logic            err_q, err_n;
  logic            wr_en;
  logic            finish;

  assign wr_en  = bus_wr && clk_en;
  assign finish = busy_q && (cnt_q == '0);

  always_comb begin
    addr_n = addr_q;
    data_n = data_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    op_n   = op_q;
    busy_n = busy_q;
    wdr_n  = wdr_q;
    inv_n  = inv_q;
    err_n  = err_q;
    if (busy_q) begin
      if (finish) begin
        busy_n = 1'b0;
        op_n   = OP_NONE;
        if (op_q == OP_PROG) begin
          addr_n = addr_q + 32'd4;
          wdr_n  = 1'b1;
        end
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
      if (wr_en && (bus_sel != REG_STAT)) begin
        err_n = 1'b1;
      end
    end else if (wr_en) begin
      case (bus_sel)
        REG_ADDR: addr_n = {bus_wdata[31:2], 2'b00};
        REG_WDATA: begin
          if (cur_hit) begin
            busy_n = 1'b1;
            op_n   = OP_PROG;
            cnt_n  = CW'(PROG_CYC - 1);
            data_n = bus_wdata;
            idx_n  = cur_idx;
            wdr_n  = 1'b0;
          end else begin
            inv_n = 1'b1;
          end
        end
        REG_CMD: begin
          if (bus_wdata[CMD_CLR]) begin
            err_n = 1'b0;
            inv_n = 1'b0;
          end
          if (bus_wdata[CMD_MASS]) begin
            busy_n = 1'b1;
            op_n   = OP_MASS;
            cnt_n  = CW'(MASS_CYC - 1);
          end else if (bus_wdata[CMD_PAGE]) begin
            if (cur_hit) begin
              busy_n = 1'b1;
              op_n   = OP_PAGE;
              cnt_n  = CW'(ERASE_CYC - 1);
              idx_n  = cur_idx;
            end else begin
              inv_n = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
      busy_q <= 1'b0;
      wdr_q  <= 1'b1;
      inv_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= addr_n;
      data_q <= data_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
      op_q   <= op_n;
      busy_q <= busy_n;
      wdr_q  <= wdr_n;
      inv_q  <= inv_n;
      err_q  <= err_n;
    end
  end

  always_comb begin
    case (bus_sel)
      REG_ADDR: bus_rdata = addr_q;
      REG_STAT: bus_rdata = {28'd0, err_q, inv_q, busy_q, wdr_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign cur_addr  = addr_q;
  assign st_busy   = busy_q;
  assign st_wdr    = wdr_q;
  assign st_inv    = inv_q;
  assign st_err    = err_q;
  assign done      = finish;
  assign done_op   = op_q;
  assign done_idx  = idx_q;
  assign done_data = data_q;
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int PAGE_WORDS = 4,
  parameter int MAIN_PAGES = 4,
  parameter int INFO_PAGES = 1,
  parameter int IDXW       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  op_e             upd_op,
  input  logic [IDXW-1:0] upd_idx,
  input  logic [31:0]     upd_data,
  input  logic            rd_hit,
  input  logic [IDXW-1:0] rd_idx,
  output logic [31:0]     rd_data
);
  localparam int MAIN_WORDS = PAGE_WORDS * MAIN_PAGES;
  localparam int TOTAL      = PAGE_WORDS * (MAIN_PAGES + INFO_PAGES);
  localparam int PGB        = $clog2(PAGE_WORDS);

  logic [31:0] rd_vec [TOTAL];

  for (genvar w = 0; w < TOTAL; w++) begin : g_word
    localparam bit IN_MAIN = (w < MAIN_WORDS);
    logic [31:0] word_q, word_n;
    logic        mass_hit;

    if (IN_MAIN) begin : g_main
      assign mass_hit = 1'b1;
    end else begin : g_info
      assign mass_hit = 1'b0;
    end

    always_comb begin
      word_n = word_q;
      case (upd_op)
        OP_PROG: if (upd_idx == IDXW'(w)) word_n = word_q & upd_data;
        OP_PAGE: if ((upd_idx >> PGB) == (IDXW'(w) >> PGB)) word_n = '1;
        OP_MASS: if (mass_hit) word_n = '1;
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (upd) begin
        word_q <= word_n;
      end
    end

    assign rd_vec[w] = word_q;
  end

  assign rd_data = rd_hit ? rd_vec[rd_idx] : '0;
endmodule

// File: rtl/nvm_flash_ctrl.sv
module nvm_flash_ctrl
  import nvm_pkg::*;
#(
  parameter logic [31:0] MAIN_BASE  = 32'h0000_0000,
  parameter logic [31:0] INFO_BASE  = 32'h0FE0_0000,
  parameter int          PAGE_WORDS = 4,
  parameter int          MAIN_PAGES = 4,
  parameter int          INFO_PAGES = 1,
  parameter int          PROG_CYC   = 3,
  parameter int          ERASE_CYC  = 8,
  parameter int          MASS_CYC   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] rd_addr,
  output logic [31:0] rd_data
);
  localparam int TOTAL = PAGE_WORDS * (MAIN_PAGES + INFO_PAGES);
  localparam int IDXW  = $clog2(TOTAL);

  logic [1:0]      rs_q;
  logic            rst_sync_n;
  logic [31:0]     cur_addr;
  logic            cur_hit;
  logic [IDXW-1:0] cur_idx;
  logic            rd_hit;
  logic [IDXW-1:0] rd_idx;
  logic            st_busy, st_wdr, st_inv, st_err;
  logic            done;
  op_e             done_op;
  logic [IDXW-1:0] done_idx;
  logic [31:0]     done_data;
  logic            unused_lo;

  assign unused_lo = ^bus_addr[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  nvm_addr_map #(
    .MAIN_BASE(MAIN_BASE), .INFO_BASE(INFO_BASE), .PAGE_WORDS(PAGE_WORDS),
    .MAIN_PAGES(MAIN_PAGES), .INFO_PAGES(INFO_PAGES), .IDXW(IDXW)
  ) u_map_cur (.addr(cur_addr), .hit(cur_hit), .idx(cur_idx));

  nvm_addr_map #(
    .MAIN_BASE(MAIN_BASE), .INFO_BASE(INFO_BASE), .PAGE_WORDS(PAGE_WORDS),
    .MAIN_PAGES(MAIN_PAGES), .INFO_PAGES(INFO_PAGES), .IDXW(IDXW)
  ) u_map_rd (.addr(rd_addr), .hit(rd_hit), .idx(rd_idx));

  nvm_ctrl #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .MASS_CYC(MASS_CYC), .IDXW(IDXW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .clk_en(clk_en), .bus_wr(bus_wr),
    .bus_sel(bus_addr[3:2]), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cur_addr(cur_addr), .cur_hit(cur_hit), .cur_idx(cur_idx),
    .st_busy(st_busy), .st_wdr(st_wdr), .st_inv(st_inv), .st_err(st_err),
    .done(done), .done_op(done_op), .done_idx(done_idx), .done_data(done_data)
  );

  nvm_array #(
    .PAGE_WORDS(PAGE_WORDS), .MAIN_PAGES(MAIN_PAGES), .INFO_PAGES(INFO_PAGES),
    .IDXW(IDXW)
  ) u_array (
    .clk(clk), .rst_n(rst_sync_n), .upd(done), .upd_op(done_op),
    .upd_idx(done_idx), .upd_data(done_data), .rd_hit(rd_hit),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );
endmodule

// File: rtl/nvm_flash_ctrl_chk.sv
module nvm_flash_ctrl_chk
  import nvm_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        clk_en,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] cur_addr,
  input logic        st_busy,
  input logic        st_wdr,
  input logic        st_inv,
  input logic        st_err,
  input logic        done,
  input op_e         done_op
);
  logic clr_req;
  assign clr_req = bus_wr && clk_en && !st_busy &&
                   (bus_addr[3:2] == REG_CMD) && bus_wdata[CMD_CLR];

  // R3: ready low only inside a busy period
  a_r3_wdr_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wdr |-> st_busy);

  // R4: address steps by four when a program finishes
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_op == OP_PROG) |=> (cur_addr == $past(cur_addr) + 32'd4));

  // R5: the finishing cycle ends the busy period
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !st_busy);

  // R7: error stays until cleared while idle
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !clr_req) |=> st_err);

  // R8: a refused operation never starts busy
  a_r8_invalid_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_inv) |-> !st_busy);

  // R9: gated writes change nothing
  a_r9_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !st_busy) |=> ($stable(cur_addr) && !st_busy));
endmodule

bind nvm_flash_ctrl nvm_flash_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .clk_en(clk_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_addr(cur_addr),
  .st_busy(st_busy), .st_wdr(st_wdr), .st_inv(st_inv), .st_err(st_err),
  .done(done), .done_op(done_op)
);

// File: tb/nvm_flash_ctrl_test.sv
module nvm_flash_ctrl_test;
  localparam logic [31:0] MB = 32'h0000_0000;
  localparam logic [31:0] IB = 32'h0FE0_0000;
  localparam int PW = 4, MP = 4, IP = 1;
  localparam int PC = 3, EC = 8, MC = 10;
  localparam int MW = PW * MP;
  localparam int TW = PW * (MP + IP);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] rd_addr = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] em [TW];

  always #5 clk = ~clk;

  nvm_flash_ctrl #(
    .MAIN_BASE(MB), .INFO_BASE(IB), .PAGE_WORDS(PW), .MAIN_PAGES(MP),
    .INFO_PAGES(IP), .PROG_CYC(PC), .ERASE_CYC(EC), .MASS_CYC(MC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [31:0] addr_of(input int i);
    return (i < MW) ? MB + 32'(4 * i) : IB + 32'(4 * (i - MW));
  endfunction

  function automatic logic [31:0] pat(input int i, input int k);
    return (32'h5A3C_96E1 * 32'(i + 1)) ^ (32'h0F1E_2D3C << k) ^ 32'(k * 7);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = {sel, 2'b00};
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
    bus_addr = {sel, 2'b00};
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input int exp_n, input string req);
    logic [31:0] s;
    int n = 0;
    rd_reg(2'd3, s);
    while (s[1] && n < 1000) begin
      n++;
      @(negedge clk);
      rd_reg(2'd3, s);
    end
    if (exp_n >= 0) check(req, 32'(n), 32'(exp_n));
  endtask

  task automatic verify_all(input string req);
    for (int i = 0; i < TW; i++) begin
      rd_addr = addr_of(i);
      #1;
      check(req, rd_data, em[i]);
    end
  endtask

  task automatic chk_reg(input logic [1:0] sel, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd_reg(sel, v);
    check(req, v, exp);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < TW; i++) em[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_reg(2'd3, 32'h1, "R1 status");
    chk_reg(2'd0, 32'h0, "R1 address");
    verify_all("R1 erased array");

    // R2 address alignment
    wr(2'd0, 32'h0000_0007);
    chk_reg(2'd0, 32'h0000_0004, "R2 low bits dropped");
    wr(2'd0, 32'h0FE0_000B);
    chk_reg(2'd0, 32'h0FE0_0008, "R2 info address");

    // R3 / R4: two programming passes over the main region
    for (int k = 0; k < 2; k++) begin
      wr(2'd0, MB);
      for (int i = 0; i < MW; i++) begin
        wr(2'd1, pat(i, k));
        chk_reg(2'd3, 32'h2, "R3 busy and not ready");
        wait_idle(PC, "R3 program cycles");
        chk_reg(2'd3, 32'h1, "R3 idle after program");
        em[i] = em[i] & pat(i, k);
        chk_reg(2'd0, MB + 32'(4 * (i + 1)), "R4 address increment");
      end
      verify_all("R3 AND programming");
    end

    // R8: address has run past the main region
    wr(2'd1, 32'h0);
    chk_reg(2'd3, 32'h5, "R8 data write out of range");
    wr(2'd2, 32'h1);
    chk_reg(2'd3, 32'h5, "R8 page erase out of range");
    verify_all("R8 array unchanged");
    wr(2'd2, 32'h8);
    chk_reg(2'd3, 32'h1, "R7 clear command");
    wr(2'd0, IB + 32'(4 * PW * IP));
    wr(2'd1, 32'h0);
    chk_reg(2'd3, 32'h5, "R8 past info region");
    wr(2'd0, 32'hFFFF_FFFC);
    wr(2'd2, 32'h1);
    chk_reg(2'd3, 32'h5, "R8 top address");
    wr(2'd2, 32'h8);

    // R11 read port outside both regions
    rd_addr = MB + 32'(4 * MW); #1;
    check("R11 read outside main", rd_data, 32'h0);
    rd_addr = IB - 32'd4; #1;
    check("R11 read below info", rd_data, 32'h0);

    // R10: program the info region
    wr(2'd0, IB);
    for (int i = 0; i < PW * IP; i++) begin
      wr(2'd1, pat(MW + i, 3));
      wait_idle(PC, "R10 info program cycles");
      em[MW + i] = em[MW + i] & pat(MW + i, 3);
    end
    verify_all("R10 info programmed");

    // R5: erase pages 0 and 2 through an address inside each
    for (int p = 0; p < MP; p += 2) begin
      wr(2'd0, MB + 32'(4 * (p * PW + (p % PW))));
      wr(2'd2, 32'h1);
      wait_idle(EC, "R5 page erase cycles");
      for (int j = 0; j < PW; j++) em[p * PW + j] = 32'hFFFF_FFFF;
      verify_all("R5 page erase contents");
    end

    // R6: both bits set -> mass erase
    wr(2'd0, MB + 32'(4 * PW));
    wr(2'd2, 32'h3);
    wait_idle(MC, "R6 mass erase cycles");
    for (int i = 0; i < MW; i++) em[i] = 32'hFFFF_FFFF;
    verify_all("R6 mass erase keeps info");

    // R10 / R5: page erase of the info page
    wr(2'd0, IB + 32'h4);
    wr(2'd2, 32'h1);
    wait_idle(EC, "R10 info page erase cycles");
    for (int i = MW; i < TW; i++) em[i] = 32'hFFFF_FFFF;
    verify_all("R10 info erased");

    // R7: writes while busy are dropped
    wr(2'd0, MB + 32'h8);
    wr(2'd2, 32'h1);
    wr(2'd1, 32'h0);
    wr(2'd0, MB + 32'h20);
    wr(2'd2, 32'h2);
    wait_idle(-1, "R7");
    chk_reg(2'd3, 32'h9, "R7 error set");
    chk_reg(2'd0, MB + 32'h8, "R7 address write dropped");
    verify_all("R7 data write dropped");
    wr(2'd1, 32'h1234_5678);
    wait_idle(PC, "R7 program while error");
    em[2] = em[2] & 32'h1234_5678;
    chk_reg(2'd3, 32'h9, "R7 error sticky");
    wr(2'd2, 32'h8);
    chk_reg(2'd3, 32'h1, "R7 error cleared");

    // R9: gated writes ignored
    clk_en = 1'b0;
    wr(2'd0, MB + 32'h30);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h2);
    chk_reg(2'd3, 32'h1, "R9 status unchanged");
    chk_reg(2'd0, MB + 32'hC, "R9 address unchanged");
    repeat (MC + 2) @(negedge clk);
    verify_all("R9 array unchanged");
    clk_en = 1'b1;
    wr(2'd0, MB + 32'h30);
    chk_reg(2'd0, MB + 32'h30, "R9 writes resume");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule